// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a circular chain of transmit descriptors held in system memory. Each descriptor is four 32-bit words: a mode word at +0, the frame buffer address at +4, a status/length word at +8 and the address of the following descriptor at +12. The walker reads a descriptor through a request/acknowledge memory port. It passes the buffer address, the length and the pad/CRC requests to a downstream transmitter and waits for the transmitter's done pulse. It then writes the result back into the descriptor, gives the descriptor back to software and moves on through the next pointer.

Software controls the walker through a small register port. It loads a list start address, sets the transmit-enable bit in a command register and writes a start demand. It can also read the address of the descriptor in progress. When the walker reaches a descriptor that software has not handed over, it raises an "unavailable" status bit, stops on that descriptor and waits for the next start demand. A completion status bit is raised for descriptors that ask for an interrupt. Both status bits are cleared by writing 1 to them, and an interrupt line is the OR of the two.

The controller is a single state machine with these states:
- IDLE: waits for a demand while transmit is enabled.
- READ_MODE, READ_BUF, READ_LEN, READ_NEXT: the four descriptor reads.
- SEND: hands the frame to the transmitter.
- WRITE_STAT, WRITE_MODE: the two write-backs.

Transitions:
- IDLE to READ_MODE on a pending demand with transmit enabled.
- READ_MODE to IDLE when the ownership bit is clear.
- Each READ state to the next READ state on acknowledge. READ_NEXT goes to SEND.
- SEND to WRITE_STAT on transmitter done.
- WRITE_STAT to WRITE_MODE on acknowledge.
- WRITE_MODE to READ_MODE on acknowledge while enabled, or to IDLE when transmit has been disabled.

Top module: `txd_ring_walker`

## Requirements
- R1: After reset the walker is idle, with no memory request and no transmit request. Status (offset 0xB0) reads 0, irq is low, and the current-descriptor register (offset 0xCC) reads 0.
- R2: A write to offset 0x88 while idle reads back at 0x88. It also becomes the current-descriptor address shown at 0xCC.
- R3: No descriptor is fetched while bit 8 of the command register (offset 0x90) is clear. A demand made during that time is held, and fetching starts once the bit is set.
- R4: A demand is a write with bit 0 set to offset 0xA0. The walker then reads the current descriptor at +0, +4, +8 and +12, in that order. It then presents the buffer address and the low 16 bits of the +8 word as the length. tx_pad equals mode bit 0 and tx_crc equals mode bit 1.
- R5: A length above 1514 is presented as 1514.
- R6: After the transmitter's done pulse, the walker writes the +8 word as the presented length plus bit 19 when tx_ok was high. It then writes the +0 word with bit 31 cleared and every other bit kept.
- R7: After write-back, the walker follows the next pointer and keeps processing while descriptors are owned (mode bit 31 set).
- R8: A descriptor fetched with mode bit 31 clear sets status bit 1. The walker then stops with the current-descriptor register on that descriptor, and the next demand restarts from it.
- R9: Status bit 0 is set when a descriptor completes with mode bit 2 set, and only then. irq is high whenever either status bit is set.
- R10: Writing to 0xB0 clears exactly the status bits written as 1. Bits written as 0 are kept.
- R11: A memory request, once raised, stays raised with an unchanged address until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rd_addr | input | 8 | Register read offset |
| cfg_rd_data | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| tx_valid | output | 1 | Frame handed to transmitter |
| tx_buf_addr | output | 32 | Frame buffer address |
| tx_len | output | 16 | Frame length in bytes |
| tx_pad | output | 1 | Padding requested |
| tx_crc | output | 1 | CRC append requested |
| tx_done | input | 1 | Transmitter finished the frame |
| tx_ok | input | 1 | Transmission succeeded, valid with tx_done |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a memory that acknowledges each request exactly once and a transmitter that pulses done only while a frame is presented. The bench's responders meet both: the memory model answers one cycle after a request and never twice in a row, and the transmitter model captures a frame once and pulses done a few cycles later. The bench issues demands and base-address writes only while the walker is idle, so a demand never arrives in the middle of a chain.

// File: rtl/txd_ring_pkg.sv
package txd_ring_pkg;
    localparam int unsigned AW       = 32;
    localparam int unsigned DW       = 32;
    localparam int unsigned RAW      = 8;
    localparam int unsigned LW       = 16;
    localparam int unsigned MAX_LEN  = 1514;

    localparam logic [RAW-1:0] OFS_BASE   = 8'h88;
    localparam logic [RAW-1:0] OFS_CMD    = 8'h90;
    localparam logic [RAW-1:0] OFS_DEMAND = 8'hA0;
    localparam logic [RAW-1:0] OFS_STAT   = 8'hB0;
    localparam logic [RAW-1:0] OFS_CUR    = 8'hCC;

    localparam int unsigned OWN_BIT   = 31;
    localparam int unsigned PAD_BIT   = 0;
    localparam int unsigned CRC_BIT   = 1;
    localparam int unsigned IEN_BIT   = 2;
    localparam int unsigned OK_BIT    = 19;
    localparam int unsigned TXEN_BIT  = 8;

    localparam logic [AW-1:0] W_MODE = 32'd0;
    localparam logic [AW-1:0] W_BUF  = 32'd4;
    localparam logic [AW-1:0] W_LEN  = 32'd8;
    localparam logic [AW-1:0] W_NEXT = 32'd12;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_MODE,
        S_READ_BUF,
        S_READ_LEN,
        S_READ_NEXT,
        S_SEND,
        S_WRITE_STAT,
        S_WRITE_MODE
    } walk_state_t;
endpackage

// File: rtl/txd_ring_regs.sv
module txd_ring_regs
    import txd_ring_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [RAW-1:0] wr_addr,
    input  logic [DW-1:0]  wdata,
    input  logic [RAW-1:0] rd_addr,
    output logic [DW-1:0]  rd_data,
    input  logic [AW-1:0]  cur_ptr,
    input  logic           set_done,
    input  logic           set_unavail,
    output logic           tx_en,
    output logic           base_wr,
    output logic [AW-1:0]  base_val,
    output logic           demand,
    output logic           irq
);
    logic [AW-1:0] base_q;
    logic [DW-1:0] cmd_q;
    logic [1:0]    status_q;

    assign base_wr  = wr_en && (wr_addr == OFS_BASE);
    assign base_val = wdata;
    assign demand   = wr_en && (wr_addr == OFS_DEMAND) && wdata[0];
    assign tx_en    = cmd_q[TXEN_BIT];
    assign irq      = |status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            cmd_q    <= '0;
            status_q <= '0;
        end else begin
            if (base_wr) base_q <= wdata;
            if (wr_en && (wr_addr == OFS_CMD)) cmd_q <= wdata;
            status_q <= (status_q & ~((wr_en && (wr_addr == OFS_STAT)) ? wdata[1:0] : 2'b00))
                        | {set_unavail, set_done};
        end
    end

    always_comb begin
        unique case (rd_addr)
            OFS_BASE: rd_data = base_q;
            OFS_CMD:  rd_data = cmd_q;
            OFS_STAT: rd_data = {30'd0, status_q};
            OFS_CUR:  rd_data = cur_ptr;
            default:  rd_data = '0;
        endcase
    end

    assert_done_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> status_q[0]);
    assert_clear_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_STAT && wdata[1] && !set_unavail) |=> !status_q[1]);
endmodule

// File: rtl/txd_ring_fsm.sv
module txd_ring_fsm
    import txd_ring_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          base_wr,
    input  logic [AW-1:0] base_val,
    input  logic          demand,
    output logic [AW-1:0] cur_ptr,
    output logic          set_done,
    output logic          set_unavail,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          tx_valid,
    output logic [AW-1:0] tx_buf_addr,
    output logic [LW-1:0] tx_len,
    output logic          tx_pad,
    output logic          tx_crc,
    input  logic          tx_done,
    input  logic          tx_ok
);
    walk_state_t   state_q, state_d;
    logic [DW-1:0] mode_q;
    logic [AW-1:0] buf_q;
    logic [LW-1:0] len_q;
    logic [AW-1:0] next_q;
    logic [AW-1:0] cur_q;
    logic          ok_q;
    logic          pend_q;
    logic [LW-1:0] len_cap;

    assign len_cap = (mem_rdata[LW-1:0] > LW'(MAX_LEN)) ? LW'(MAX_LEN) : mem_rdata[LW-1:0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (pend_q && tx_en) state_d = S_READ_MODE;
            S_READ_MODE:  if (mem_ack) state_d = mem_rdata[OWN_BIT] ? S_READ_BUF : S_IDLE;
            S_READ_BUF:   if (mem_ack) state_d = S_READ_LEN;
            S_READ_LEN:   if (mem_ack) state_d = S_READ_NEXT;
            S_READ_NEXT:  if (mem_ack) state_d = S_SEND;
            S_SEND:       if (tx_done) state_d = S_WRITE_STAT;
            S_WRITE_STAT: if (mem_ack) state_d = S_WRITE_MODE;
            S_WRITE_MODE: if (mem_ack) state_d = tx_en ? S_READ_MODE : S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            buf_q  <= '0;
            len_q  <= '0;
            next_q <= '0;
            cur_q  <= '0;
            ok_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (state_q == S_IDLE && base_wr) cur_q <= base_val;
            if (demand) pend_q <= 1'b1;
            else if (state_q == S_IDLE && state_d != S_IDLE) pend_q <= 1'b0;
            unique case (state_q)
                S_READ_MODE:  if (mem_ack) mode_q <= mem_rdata;
                S_READ_BUF:   if (mem_ack) buf_q  <= mem_rdata;
                S_READ_LEN:   if (mem_ack) len_q  <= len_cap;
                S_READ_NEXT:  if (mem_ack) next_q <= mem_rdata;
                S_SEND:       if (tx_done) ok_q   <= tx_ok;
                S_WRITE_MODE: if (mem_ack) cur_q  <= next_q;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        unique case (state_q)
            S_IDLE:       ;
            S_READ_MODE:  begin mem_req = 1'b1; mem_addr = cur_q + W_MODE; end
            S_READ_BUF:   begin mem_req = 1'b1; mem_addr = cur_q + W_BUF;  end
            S_READ_LEN:   begin mem_req = 1'b1; mem_addr = cur_q + W_LEN;  end
            S_READ_NEXT:  begin mem_req = 1'b1; mem_addr = cur_q + W_NEXT; end
            S_SEND:       tx_valid = 1'b1;
            S_WRITE_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q + W_LEN;
                mem_wdata = {12'd0, ok_q, 3'd0, len_q};
            end
            S_WRITE_MODE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q + W_MODE;
                mem_wdata = {1'b0, mode_q[OWN_BIT-1:0]};
            end
            default: ;
        endcase
    end

    assign set_done    = (state_q == S_WRITE_MODE) && mem_ack && mode_q[IEN_BIT];
    assign set_unavail = (state_q == S_READ_MODE) && mem_ack && !mem_rdata[OWN_BIT];
    assign cur_ptr     = cur_q;
    assign tx_buf_addr = buf_q;
    assign tx_len      = len_q;
    assign tx_pad      = mode_q[PAD_BIT];
    assign tx_crc      = mode_q[CRC_BIT];

    assert_hold_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !tx_en) |=> !mem_req);
    assert_len_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_len <= LW'(MAX_LEN)));
    assert_own_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr == cur_q) |-> !mem_wdata[OWN_BIT]);
    assert_stop_unowned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_unavail |=> !mem_req);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
    import txd_ring_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr_en,
    input  logic [RAW-1:0] cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    input  logic [RAW-1:0] cfg_rd_addr,
    output logic [DW-1:0]  cfg_rd_data,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata,
    output logic           tx_valid,
    output logic [AW-1:0]  tx_buf_addr,
    output logic [LW-1:0]  tx_len,
    output logic           tx_pad,
    output logic           tx_crc,
    input  logic           tx_done,
    input  logic           tx_ok,
    output logic           irq
);
    logic          tx_en, base_wr, demand, set_done, set_unavail;
    logic [AW-1:0] base_val, cur_ptr;

    txd_ring_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_addr(cfg_addr), .wdata(cfg_wdata),
        .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
        .cur_ptr(cur_ptr), .set_done(set_done), .set_unavail(set_unavail),
        .tx_en(tx_en), .base_wr(base_wr), .base_val(base_val),
        .demand(demand), .irq(irq)
    );

    txd_ring_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .tx_en(tx_en), .base_wr(base_wr), .base_val(base_val), .demand(demand),
        .cur_ptr(cur_ptr), .set_done(set_done), .set_unavail(set_unavail),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
        .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .tx_ok(tx_ok)
    );
endmodule

// File: tb/tb_txd_ring_walker.sv
`timescale 1ns/1ps
module tb_txd_ring_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  cfg_rd_addr = '0;
    logic [31:0] cfg_rd_data;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_pad, tx_crc;
    logic [31:0] tx_buf_addr;
    logic [15:0] tx_len;
    logic        tx_done = 1'b0;
    logic        tx_ok = 1'b0;
    logic        irq;

    always #5 clk = ~clk;

    txd_ring_walker dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
        .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .tx_ok(tx_ok),
        .irq(irq)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // memory model: one access per request, acknowledged a cycle later
    logic [31:0] mem [64];
    logic [31:0] rd_log [16];
    int          rd_cnt = 0;
    int          acc_cnt = 0;
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            acc_cnt <= acc_cnt + 1;
            if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
            else begin
                mem_rdata <= mem[mem_addr[7:2]];
                if (rd_cnt < 16) rd_log[rd_cnt] <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    // transmitter model
    logic        ok_next = 1'b1;
    int          tcnt = 0;
    int          tx_count = 0;
    logic [31:0] cap_buf;
    logic [15:0] cap_len;
    logic        cap_pad, cap_crc;
    always @(posedge clk) begin
        tx_done <= 1'b0;
        if (tcnt != 0) begin
            tcnt <= tcnt - 1;
            if (tcnt == 1) begin
                tx_done <= 1'b1;
                tx_ok   <= ok_next;
            end
        end else if (tx_valid && !tx_done) begin
            tcnt     <= 3;
            tx_count <= tx_count + 1;
            cap_buf  <= tx_buf_addr;
            cap_len  <= tx_len;
            cap_pad  <= tx_pad;
            cap_crc  <= tx_crc;
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung");
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd_addr = a;
        #1 d = cfg_rd_data;
    endtask

    task automatic wait_unavail();
        logic [31:0] s;
        for (int k = 0; k < 400; k++) begin
            rd(8'hB0, s);
            if (s[1]) return;
        end
    endtask

    task automatic put_desc(input int at, input logic [31:0] m, input logic [31:0] b,
                            input logic [31:0] l, input logic [31:0] n);
        mem[at/4]     = m;
        mem[at/4 + 1] = b;
        mem[at/4 + 2] = l;
        mem[at/4 + 3] = n;
    endtask

    // {mode[2:0], length word, tx ok, expected length, expected done flag}
    localparam logic [52:0] VEC [5] = '{
        {3'b111, 32'h0000003C, 1'b1, 16'd60,   1'b1},
        {3'b000, 32'h000005EA, 1'b0, 16'd1514, 1'b0},
        {3'b001, 32'h000007D0, 1'b1, 16'd1514, 1'b0},
        {3'b100, 32'hABCD0040, 1'b1, 16'd64,   1'b1},
        {3'b010, 32'h000005EB, 1'b1, 16'd1514, 1'b0}
    };

    initial begin
        logic [31:0] v;
        int          t0, a0;
        for (int k = 0; k < 64; k++) mem[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'hB0, v); check("R1 status", v, 0);
        rd(8'hCC, v); check("R1 current", v, 0);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 mem_req", {31'd0, mem_req}, 0);
        check("R1 tx_valid", {31'd0, tx_valid}, 0);

        wr(8'h90, 32'h100);

        for (int i = 0; i < 5; i++) begin
            logic [2:0]  m;
            logic [31:0] lw, exp_stat;
            logic        okv, edone;
            logic [15:0] elen;
            {m, lw, okv, elen, edone} = VEC[i];
            exp_stat = {12'd0, okv, 3'd0, elen};
            put_desc(32'h40, 32'h80AB0000 | {29'd0, m}, 32'h1000 + i, lw, 32'h50);
            mem[20] = 32'h0;
            ok_next = okv;
            rd_cnt = 0;
            wr(8'h88, 32'h40);
            rd(8'h88, v); check("R2 base readback", v, 32'h40);
            rd(8'hCC, v); check("R2 current from base", v, 32'h40);
            t0 = tx_count;
            wr(8'hA0, 32'h1);
            wait_unavail();
            check("R4 one frame", tx_count - t0, 1);
            check("R4 buffer", cap_buf, 32'h1000 + i);
            check("R5 length", {16'd0, cap_len}, {16'd0, elen});
            check("R4 pad", {31'd0, cap_pad}, {31'd0, m[0]});
            check("R4 crc", {31'd0, cap_crc}, {31'd0, m[1]});
            check("R6 status word", mem[18], exp_stat);
            check("R6 mode released", mem[16], 32'h00AB0000 | {29'd0, m});
            rd(8'hCC, v); check("R8 stop on unowned", v, 32'h50);
            rd(8'hB0, v); check("R9 done flag", v, {30'd0, 1'b1, edone});
            check("R9 irq", {31'd0, irq}, 1);
            if (i == 0) begin
                check("R4 read 0", rd_log[0], 32'h40);
                check("R4 read 1", rd_log[1], 32'h44);
                check("R4 read 2", rd_log[2], 32'h48);
                check("R4 read 3", rd_log[3], 32'h4C);
                check("R7 next read", rd_log[4], 32'h50);
                wr(8'hB0, 32'h2);
                rd(8'hB0, v); check("R10 partial clear", v, 1);
                wr(8'hB0, 32'h0);
                rd(8'hB0, v); check("R10 zero write keeps", v, 1);
            end
            wr(8'hB0, 32'h3);
            rd(8'hB0, v); check("R10 cleared", v, 0);
            check("R10 irq low", {31'd0, irq}, 0);
        end

        // R7 chain of three owned descriptors
        ok_next = 1'b1;
        put_desc(32'h00, 32'h80000000, 32'h2000, 32'd100, 32'h10);
        put_desc(32'h10, 32'h80000000, 32'h2100, 32'd200, 32'h20);
        put_desc(32'h20, 32'h80000000, 32'h2200, 32'd300, 32'h30);
        put_desc(32'h30, 32'h0, 32'h2300, 32'd400, 32'h50);
        wr(8'h88, 32'h0);
        t0 = tx_count;
        wr(8'hA0, 32'h1);
        wait_unavail();
        check("R7 three frames", tx_count - t0, 3);
        check("R7 last buffer", cap_buf, 32'h2200);
        check("R7 mode 2 released", mem[8], 32'h0);
        rd(8'hCC, v); check("R7 stopped at fourth", v, 32'h30);
        wr(8'hB0, 32'h3);

        // R8 resume from the stalled descriptor
        mem[12] = 32'h80000000;
        mem[20] = 32'h0;
        t0 = tx_count;
        wr(8'hA0, 32'h1);
        wait_unavail();
        check("R8 resumed frame", tx_count - t0, 1);
        check("R8 resumed buffer", cap_buf, 32'h2300);
        rd(8'hCC, v); check("R8 moved on", v, 32'h50);
        wr(8'hB0, 32'h3);

        // R3 demand held while disabled
        wr(8'h90, 32'h0);
        put_desc(32'h50, 32'h80000000, 32'h3000, 32'd50, 32'h60);
        mem[24] = 32'h0;
        t0 = tx_count;
        a0 = acc_cnt;
        wr(8'hA0, 32'h1);
        repeat (40) @(negedge clk);
        check("R3 no access while off", acc_cnt - a0, 0);
        check("R3 no frame while off", tx_count - t0, 0);
        wr(8'h90, 32'h100);
        wait_unavail();
        check("R3 held demand served", tx_count - t0, 1);
        rd(8'hCC, v); check("R3 pointer after", v, 32'h60);

        summary();
    end
endmodule